// File: doc/BRIEF.md
# Same-ID Transaction Ordering Tracker

This block keeps translation transactions that share an order identifier completing in the order they arrived. Reads and writes are ordered separately. Each transaction is known by a tag, a small slot number that the surrounding engine gives it. When the transaction starts, the engine registers its tag with an order ID and a direction. From the next cycle on, the block shows a per-tag hold bit. A transaction may proceed only while its hold bit is low. When it completes, the engine releases its tag.

Each pair of order ID and direction owns a queue of bounded depth. Only the oldest transaction in a queue, its head, is free. A release removes the tag from its queue wherever it sits. Every transaction behind the removed one moves up one place, so all waiters see the release at the same time. A register into a full queue is refused through a ready signal. A release of a tag that is not tracked raises an error pulse. So does a register of a tag that is already tracked.

Top module: `order_tracker`

## Requirements
- R1: After reset, every hold bit is 1, reg_ready is 1 and both error outputs are 0.
- R2: A tag accepted into an empty queue has its hold bit at 0 in the cycle after the accepting clock edge.
- R3: Transactions with the same order ID and the same direction are served oldest first. A later tag keeps hold at 1 while any earlier tag of its queue is tracked. Its hold bit falls in the cycle after the last earlier tag is released.
- R4: A read (reg_write = 0) and a write (reg_write = 1) with the same order ID sit in different queues and never hold each other.
- R5: Transactions with different order IDs never hold each other.
- R6: A release may remove a tag that is not the head. The remaining tags of that queue keep their relative order, and the head stays the head.
- R7: While the queue selected by reg_id and reg_write holds QDEPTH tags, reg_ready is 0 and a register request is not taken. Other queues stay ready.
- R8: A release of a tag that is not tracked sets rel_err for one cycle after that edge and changes no hold bit.
- R9: A register of a tag that is already tracked is dropped and sets dup_err for one cycle. The tag stays in its original queue.
- R10: A release and a register in the same cycle and the same queue are both applied. The new tag is placed behind every tag that remains.
- R11: The hold bit of a tag that is not tracked is 1, and it returns to 1 in the cycle after that tag's release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register request |
| reg_ready | output | 1 | Selected queue has room |
| reg_id | input | $clog2(NUM_IDS) | Order ID of the registering transaction |
| reg_write | input | 1 | Direction: 0 read, 1 write |
| reg_tag | input | $clog2(NUM_TAGS) | Tag being registered |
| rel_valid | input | 1 | Release request |
| rel_tag | input | $clog2(NUM_TAGS) | Tag being released |
| hold | output | NUM_TAGS | Per-tag hold; 0 only for a tracked tag at the head of its queue |
| rel_err | output | 1 | Pulse: release of an untracked tag |
| dup_err | output | 1 | Pulse: register of an already tracked tag |

## Verification
Pairs of tags are registered with the same ID and direction, the same ID and opposite direction, and different IDs. These patterns separate true serialisation from over-blocking across directions or IDs. Three-deep queues are released from the middle and then from the head, which shows whether only the entries behind the removed one move up. A full queue, absent and duplicate tags, and a release together with a register in the same cycle cover the boundary cases. An untracked tag is proved by its release raising rel_err, and a duplicate is proved harmless by the order of its original queue.

// File: rtl/otrk_pkg.sv
package otrk_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    localparam int unsigned DEF_NUM_IDS  = 4;
    localparam int unsigned DEF_QDEPTH   = 4;
    localparam int unsigned DEF_NUM_TAGS = 8;

    // width of an index over n items, never zero
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // width of a count reaching n inclusive
    function automatic int unsigned cnt_w(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/otrk_occupancy.sv
module otrk_occupancy #(
    parameter int unsigned NUM_TAGS = 8,
    parameter int unsigned NUM_Q    = 8,
    parameter int unsigned QW       = 3,
    parameter int unsigned OCC_W    = 3
) (
    input  logic [NUM_TAGS-1:0] slot_valid,
    input  logic [QW-1:0]       slot_queue [NUM_TAGS],
    output logic [OCC_W-1:0]    occ        [NUM_Q]
);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        always_comb begin
            occ[q] = '0;
            for (int t = 0; t < NUM_TAGS; t++) begin
                if (slot_valid[t] && (slot_queue[t] == QW'(q)))
                    occ[q] = occ[q] + OCC_W'(1);
            end
        end
    end

endmodule

// File: rtl/otrk_slot.sv
module otrk_slot #(
    parameter int unsigned QW    = 3,
    parameter int unsigned POS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_hit,
    input  logic [QW-1:0]    reg_queue,
    input  logic [POS_W-1:0] reg_pos,
    input  logic             rel_hit,
    input  logic             rel_any,
    input  logic [QW-1:0]    rel_queue,
    input  logic [POS_W-1:0] rel_pos,
    output logic             valid,
    output logic [QW-1:0]    queue,
    output logic [POS_W-1:0] pos,
    output logic             at_head
);

    logic moves_up;

    // an entry behind the released one in the same queue moves one place forward
    assign moves_up = valid && rel_any && !rel_hit &&
                      (rel_queue == queue) && (pos > rel_pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            queue <= '0;
            pos   <= '0;
        end else if (reg_hit) begin
            valid <= 1'b1;
            queue <= reg_queue;
            pos   <= reg_pos;
        end else if (rel_hit) begin
            valid <= 1'b0;
            pos   <= '0;
        end else if (moves_up) begin
            pos <= pos - POS_W'(1);
        end
    end

    assign at_head = valid && (pos == '0);

endmodule

// File: rtl/order_tracker.sv
module order_tracker
    import otrk_pkg::*;
#(
    parameter int unsigned NUM_IDS  = DEF_NUM_IDS,
    parameter int unsigned QDEPTH   = DEF_QDEPTH,
    parameter int unsigned NUM_TAGS = DEF_NUM_TAGS,
    localparam int unsigned ID_W    = idx_w(NUM_IDS),
    localparam int unsigned TAG_W   = idx_w(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_valid,
    output logic                reg_ready,
    input  logic [ID_W-1:0]     reg_id,
    input  logic                reg_write,
    input  logic [TAG_W-1:0]    reg_tag,
    input  logic                rel_valid,
    input  logic [TAG_W-1:0]    rel_tag,
    output logic [NUM_TAGS-1:0] hold,
    output logic                rel_err,
    output logic                dup_err
);

    localparam int unsigned QW    = ID_W + 1;
    localparam int unsigned NUM_Q = 2 ** QW;
    localparam int unsigned POS_W = idx_w(QDEPTH);
    localparam int unsigned OCC_W = cnt_w(QDEPTH);

    logic [NUM_TAGS-1:0] slot_valid;
    logic [QW-1:0]       slot_queue [NUM_TAGS];
    logic [POS_W-1:0]    slot_pos   [NUM_TAGS];
    logic [NUM_TAGS-1:0] slot_head;
    logic [OCC_W-1:0]    occ        [NUM_Q];

    logic [QW-1:0]    q_in;
    logic [OCC_W-1:0] occ_in;
    logic             tag_busy;
    logic             reg_fire;
    logic             rel_ok;
    logic [QW-1:0]    rel_q;
    logic [POS_W-1:0] rel_p;
    logic             rel_same_q;
    logic [POS_W-1:0] new_pos;
    dir_e             dir_in;

    otrk_occupancy #(
        .NUM_TAGS (NUM_TAGS),
        .NUM_Q    (NUM_Q),
        .QW       (QW),
        .OCC_W    (OCC_W)
    ) u_occ (
        .slot_valid (slot_valid),
        .slot_queue (slot_queue),
        .occ        (occ)
    );

    // queue index: order ID in the upper bits, direction in the lowest bit
    assign dir_in     = dir_e'(reg_write);
    assign q_in       = {reg_id, dir_in};
    assign occ_in     = occ[q_in];
    assign reg_ready  = (occ_in < OCC_W'(QDEPTH));
    assign tag_busy   = slot_valid[reg_tag];
    assign reg_fire   = reg_valid && reg_ready && !tag_busy;

    assign rel_ok     = rel_valid && slot_valid[rel_tag];
    assign rel_q      = slot_queue[rel_tag];
    assign rel_p      = slot_pos[rel_tag];
    assign rel_same_q = rel_ok && (rel_q == q_in);

    // the new entry lands behind every entry that survives this cycle
    assign new_pos    = POS_W'(occ_in - (rel_same_q ? OCC_W'(1) : OCC_W'(0)));

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_slot
        otrk_slot #(
            .QW    (QW),
            .POS_W (POS_W)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .reg_hit   (reg_fire && (reg_tag == TAG_W'(t))),
            .reg_queue (q_in),
            .reg_pos   (new_pos),
            .rel_hit   (rel_ok && (rel_tag == TAG_W'(t))),
            .rel_any   (rel_ok),
            .rel_queue (rel_q),
            .rel_pos   (rel_p),
            .valid     (slot_valid[t]),
            .queue     (slot_queue[t]),
            .pos       (slot_pos[t]),
            .at_head   (slot_head[t])
        );
    end

    assign hold = ~slot_head;

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_err <= 1'b0;
            dup_err <= 1'b0;
        end else begin
            rel_err <= rel_valid && !slot_valid[rel_tag];
            dup_err <= reg_valid && reg_ready && tag_busy;
        end
    end

endmodule

// File: rtl/order_tracker_chk.sv
module order_tracker_chk
    import otrk_pkg::*;
#(
    parameter int unsigned NUM_IDS  = DEF_NUM_IDS,
    parameter int unsigned QDEPTH   = DEF_QDEPTH,
    parameter int unsigned NUM_TAGS = DEF_NUM_TAGS,
    localparam int unsigned ID_W    = idx_w(NUM_IDS),
    localparam int unsigned TAG_W   = idx_w(NUM_TAGS),
    localparam int unsigned QW      = ID_W + 1,
    localparam int unsigned NUM_Q   = 2 ** QW,
    localparam int unsigned OCC_W   = cnt_w(QDEPTH)
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_valid,
    input logic                reg_ready,
    input logic [ID_W-1:0]     reg_id,
    input logic                reg_write,
    input logic [TAG_W-1:0]    reg_tag,
    input logic                rel_valid,
    input logic [TAG_W-1:0]    rel_tag,
    input logic [NUM_TAGS-1:0] hold,
    input logic                rel_err,
    input logic                dup_err,
    input logic [NUM_TAGS-1:0] slot_valid,
    input logic [QW-1:0]       slot_queue [NUM_TAGS],
    input logic [OCC_W-1:0]    occ        [NUM_Q]
);

    logic [QW-1:0] chk_q;
    assign chk_q = {reg_id, reg_write};

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic [NUM_TAGS-1:0] free_mask;
        always_comb begin
            for (int t = 0; t < NUM_TAGS; t++)
                free_mask[t] = slot_valid[t] && (slot_queue[t] == QW'(q)) && !hold[t];
        end

        AST_ONE_HEAD: assert property (@(posedge clk) disable iff (rst)
            $onehot0(free_mask)); // R3

        AST_NONEMPTY_HAS_HEAD: assert property (@(posedge clk) disable iff (rst)
            (occ[q] != '0) |-> (free_mask != '0)); // R6

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            occ[q] <= OCC_W'(QDEPTH)); // R7
    end

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (occ[chk_q] == OCC_W'(QDEPTH)) |-> !reg_ready); // R7

    AST_EMPTY_REG_FREE: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_ready && !slot_valid[reg_tag] && occ[chk_q] == '0 &&
         !(rel_valid && rel_tag == reg_tag)) |=> !hold[$past(reg_tag)]); // R2

    AST_REL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && slot_valid[rel_tag]) |=> hold[$past(rel_tag)]); // R11

    AST_ABSENT_REL_ERR: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && !slot_valid[rel_tag]) |=> rel_err); // R8

    AST_DUP_ERR: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_ready && slot_valid[reg_tag]) |=> dup_err); // R9

endmodule

bind order_tracker order_tracker_chk #(
    .NUM_IDS  (NUM_IDS),
    .QDEPTH   (QDEPTH),
    .NUM_TAGS (NUM_TAGS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_valid  (reg_valid),
    .reg_ready  (reg_ready),
    .reg_id     (reg_id),
    .reg_write  (reg_write),
    .reg_tag    (reg_tag),
    .rel_valid  (rel_valid),
    .rel_tag    (rel_tag),
    .hold       (hold),
    .rel_err    (rel_err),
    .dup_err    (dup_err),
    .slot_valid (slot_valid),
    .slot_queue (slot_queue),
    .occ        (occ)
);

// File: tb/order_tracker_tb.sv
module order_tracker_tb;

    localparam int NI = 4;
    localparam int QD = 4;
    localparam int NT = 8;
    localparam int IW = 2;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_valid = 1'b0;
    logic          reg_ready;
    logic [IW-1:0] reg_id = '0;
    logic          reg_write = 1'b0;
    logic [TW-1:0] reg_tag = '0;
    logic          rel_valid = 1'b0;
    logic [TW-1:0] rel_tag = '0;
    logic [NT-1:0] hold;
    logic          rel_err;
    logic          dup_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    order_tracker #(.NUM_IDS(NI), .QDEPTH(QD), .NUM_TAGS(NT)) u_dut (
        .clk(clk), .rst(rst),
        .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_id(reg_id),
        .reg_write(reg_write), .reg_tag(reg_tag),
        .rel_valid(rel_valid), .rel_tag(rel_tag),
        .hold(hold), .rel_err(rel_err), .dup_err(dup_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one clock of stimulus: inputs set after a falling edge, results seen at the next one
    task automatic step(input bit rv, input int id, input bit wr, input int tg,
                        input bit lv, input int lt);
        @(negedge clk);
        reg_valid = rv; reg_id = IW'(id); reg_write = wr; reg_tag = TW'(tg);
        rel_valid = lv; rel_tag = TW'(lt);
        @(negedge clk);
        reg_valid = 1'b0; rel_valid = 1'b0;
    endtask

    task automatic add(input int id, input bit wr, input int tg);
        step(1, id, wr, tg, 0, 0);
    endtask

    task automatic drop(input int tg);
        step(0, 0, 0, 0, 1, tg);
    endtask

    task automatic t_reset();
        chk("R1", "hold after reset", 32'(hold), 32'hFF);
        chk("R1", "ready after reset", 32'(reg_ready), 1);
        chk("R1", "errors after reset", {30'd0, rel_err, dup_err}, 0);
    endtask

    task automatic t_single();
        add(0, 0, 0);
        chk("R2", "head of empty queue", 32'(hold), 32'hFE);
        drop(0);
        chk("R11", "hold back after release", 32'(hold), 32'hFF);
    endtask

    task automatic t_serial();
        add(1, 0, 1);
        add(1, 0, 2);
        chk("R3", "first free", 32'(hold[1]), 0);
        chk("R3", "second held", 32'(hold[2]), 1);
        drop(1);
        chk("R3", "second free after release", 32'(hold[2]), 0);
        drop(2);
    endtask

    task automatic t_dir();
        add(2, 0, 3);
        add(2, 1, 4);
        chk("R4", "read and write same id both free", 32'({hold[3], hold[4]}), 0);
        drop(3); drop(4);
    endtask

    task automatic t_ids();
        add(0, 1, 5);
        add(3, 1, 6);
        chk("R5", "different ids both free", 32'({hold[5], hold[6]}), 0);
        drop(5); drop(6);
    endtask

    task automatic t_middle();
        add(1, 1, 0); add(1, 1, 1); add(1, 1, 2);
        drop(1);
        chk("R6", "head stays free", 32'(hold[0]), 0);
        chk("R6", "tail still held", 32'(hold[2]), 1);
        drop(0);
        chk("R6", "tail free after head leaves", 32'(hold[2]), 0);
        drop(2);
    endtask

    task automatic t_full();
        for (int t = 0; t < QD; t++) add(3, 0, t);
        @(negedge clk);
        reg_valid = 1'b1; reg_id = 2'd3; reg_write = 1'b0; reg_tag = 3'd4;
        #1 chk("R7", "full queue not ready", 32'(reg_ready), 0);
        reg_write = 1'b1;
        #1 chk("R7", "other direction ready", 32'(reg_ready), 1);
        reg_write = 1'b0;
        @(negedge clk);
        reg_valid = 1'b0;
        drop(4);
        chk("R7", "refused tag untracked", 32'(rel_err), 1);
        for (int t = 0; t < QD; t++) drop(t);
        chk("R7", "all drained", 32'(hold), 32'hFF);
    endtask

    task automatic t_absent();
        add(2, 1, 0);
        drop(7);
        chk("R8", "rel_err pulse", 32'(rel_err), 1);
        chk("R8", "hold unchanged", 32'(hold), 32'hFE);
        step(0, 0, 0, 0, 0, 0);
        chk("R8", "rel_err clears", 32'(rel_err), 0);
        drop(0);
    endtask

    task automatic t_dup();
        add(0, 0, 0);
        add(2, 1, 0);
        chk("R9", "dup_err pulse", 32'(dup_err), 1);
        add(2, 1, 1);
        chk("R9", "tag not moved to new queue", 32'(hold[1]), 0);
        add(0, 0, 2);
        chk("R9", "tag still heads old queue", 32'({hold[0], hold[2]}), 32'b01);
        drop(0); drop(1); drop(2);
        chk("R9", "clean after dup", 32'(hold), 32'hFF);
    endtask

    task automatic t_same_cycle();
        add(1, 0, 0);
        step(1, 1, 0, 1, 1, 0);
        chk("R10", "new tag free after swap", 32'({hold[0], hold[1]}), 32'b10);
        add(1, 0, 2);
        step(1, 1, 0, 3, 1, 1);
        chk("R10", "old tail promoted, new held", 32'({hold[2], hold[3]}), 32'b01);
        drop(2);
        chk("R10", "new tag free last", 32'(hold[3]), 0);
        drop(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_serial();
        t_dir();
        t_ids();
        t_middle();
        t_full();
        t_absent();
        t_dup();
        t_same_cycle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule